// File: doc/BRIEF.md
# I2C Bus Condition Sequencer

This block is the master-side sequencer that places START, STOP and repeated START conditions on an open-drain two-wire bus. It never drives a line high. Each line has a drive-low enable output, and the line level comes back on a separate input. The CPU triggers a condition by writing the status register. Only the three top bits of the written byte (master, transmit and bus-busy, bits 7:5) reach the block, on `wr_mode`. Every phase is counted in clock cycles. `fast_mode` chooses between the standard count set and the high-speed count set.

After a START the block clears its 3-bit bit counter and raises `byte_go`. This is a stub handshake that stands in for the byte shifter. Each `bit_tick` pulse advances the counter, and the eighth pulse ends the byte. The block keeps a bus-busy flag. Its own conditions set and clear the flag after a timed delay. While the block is idle, the flag follows START and STOP conditions that other masters produce, as seen by a synchronizing line monitor. A START request is refused while another master holds the bus.

The states are:
- `S_IDLE`: both lines released.
- `S_SETUP`: both lines released, for the setup count.
- `S_HOLD`: SDA low and SCL released, for the hold count.
- `S_BYTE`: SCL low while ticks arrive.
- `S_HELD`: SCL low, SDA released, the block owns the bus.
- `S_ARM`: SCL low, SDA released, a repeated START is armed.
- `S_DROP`: both lines low for one cycle.
- `S_PSETUP`: SCL released and SDA low, for the setup count.

The transitions are:
- IDLE→SETUP on a start write while the bus is free.
- SETUP→HOLD when the setup count ends.
- HOLD→BYTE when the hold count ends.
- BYTE→HELD on the eighth tick.
- HELD→DROP on a stop write.
- HELD→ARM on an arm write.
- ARM→SETUP on a start write.
- ARM→DROP on a stop write.
- DROP→PSETUP after one cycle.
- PSETUP→IDLE when the setup count ends.
- Any state→IDLE while `enable` is low.

Top module: `i2c_cond_gen`

## Requirements
- R1: During and after reset, both drive-low outputs are 0, `bus_busy` is 0, `bit_cnt` is 0 and `byte_go` is 0.
- R2: A write with `wr_mode`=3'b111 in S_IDLE, with the interface enabled and `bus_busy`=0, keeps both lines released for S cycles. SDA is then pulled low exactly S cycles after the write edge, with SCL still released.
- R3: SCL is pulled low exactly S+H cycles after the START write edge. In that same cycle `bit_cnt` reads 0 and `byte_go` goes high.
- R4: After a START from S_IDLE, `bus_busy` becomes 1 exactly S+B cycles after the write edge, and not earlier.
- R5: With `fast_mode`=0, S=20, H=20 and B=12. With `fast_mode`=1, S=10, H=10 and B=6.
- R6: A write with `wr_mode`=3'b110 in S_HELD or S_ARM pulls both lines low on the next cycle. SCL is released one cycle later. SDA is released S cycles after that. `bus_busy` stays 1 until it clears B cycles after the SDA release.
- R7: A write with `wr_mode`=3'b001 in S_HELD releases SDA while SCL stays low. A later write of 3'b111 runs the R2/R3 timing from that write. `bus_busy` stays 1 throughout.
- R8: A start write in S_IDLE while `bus_busy`=1 causes no line change, leaves `byte_go` low and leaves `bit_cnt` unchanged.
- R9: In S_IDLE, when no own flag update is pending, an SDA fall while SCL is high on the inputs sets `bus_busy`. An SDA rise while SCL is high clears it. Each takes effect SYNC_STAGES+1 cycles after the line change.
- R10: While `enable` is 0, the next cycle shows both lines released and `bus_busy`=0. Writes and line activity are ignored.
- R11: In S_BYTE each `bit_tick` increments `bit_cnt`. The tick that arrives at count 7 moves to S_HELD with `bit_cnt`=7, `byte_go`=0 and SCL held low.
- R12: Stop and arm writes in S_IDLE, and all writes in S_BYTE, have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock (φ) |
| rst_n | input | 1 | active-low reset |
| enable | input | 1 | interface enable |
| fast_mode | input | 1 | 1 selects the high-speed counts |
| wr_stat | input | 1 | status register write strobe |
| wr_mode | input | 3 | written bits 7:5 (master, transmit, busy) |
| bit_tick | input | 1 | stub byte clock: one bit done |
| scl_in | input | 1 | SCL line level readback |
| sda_in | input | 1 | SDA line level readback |
| scl_drive_low | output | 1 | pull SCL low |
| sda_drive_low | output | 1 | pull SDA low |
| bus_busy | output | 1 | bus-busy flag |
| bit_cnt | output | 3 | bit counter |
| byte_go | output | 1 | byte clocking requested |

## Verification
Two things overlap in the block's own STOP. The line monitor sees the block's own SDA rise while SCL is high in the same window where the delayed flag-clear timer is still running. A wrong gate would clear `bus_busy` a few cycles after the release instead of B cycles after it. Every STOP, directed and random, in both modes, checks the flag at S+B and at S+B+1 cycles after the write. A second overlap is `enable` dropping in the middle of a START hold while the flag timer is pending. The next cycle must show all lines released and the flag clear.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_HOLD,
        S_BYTE,
        S_HELD,
        S_ARM,
        S_DROP,
        S_PSETUP
    } cg_state_t;

    // written status bits 7:5 = master, transmit, busy
    localparam logic [2:0] OP_START = 3'b111;
    localparam logic [2:0] OP_STOP  = 3'b110;
    localparam logic [2:0] OP_ARM   = 3'b001;

endpackage

// File: rtl/i2c_cond_line_mon.sv
module i2c_cond_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic seen_start,
    output logic seen_stop
);

    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sync;
    logic [TOP:0] sda_sync;
    logic         sda_prev;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[TOP-1:0], scl_in};
                    sda_sync <= {sda_sync[TOP-1:0], sda_in};
                end
            end
        end else begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= scl_in;
                    sda_sync <= sda_in;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sda_prev <= 1'b1;
        else        sda_prev <= sda_sync[TOP];
    end

    always_comb begin
        seen_start = scl_sync[TOP] &  sda_prev & ~sda_sync[TOP];
        seen_stop  = scl_sync[TOP] & ~sda_prev &  sda_sync[TOP];
    end

endmodule

// File: rtl/i2c_cond_phase_timer.sv
module i2c_cond_phase_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - W'(1);
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/i2c_cond_busy.sv
module i2c_cond_busy #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable,
    input  logic         idle,
    input  logic         own_set,
    input  logic         own_clr,
    input  logic [W-1:0] delay,
    input  logic         seen_start,
    input  logic         seen_stop,
    output logic         busy
);

    logic         busy_q;
    logic         pend_q;
    logic         dir_q;
    logic [W-1:0] tmr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
            dir_q  <= 1'b0;
            tmr_q  <= '0;
        end else if (!enable) begin
            busy_q <= 1'b0;
            pend_q <= 1'b0;
        end else if (own_set || own_clr) begin
            pend_q <= 1'b1;
            dir_q  <= own_set;
            tmr_q  <= delay;
        end else if (pend_q) begin
            if (tmr_q <= W'(1)) begin
                busy_q <= dir_q;
                pend_q <= 1'b0;
            end else begin
                tmr_q <= tmr_q - W'(1);
            end
        end else if (idle) begin
            if (seen_start)     busy_q <= 1'b1;
            else if (seen_stop) busy_q <= 1'b0;
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/i2c_cond_gen.sv
module i2c_cond_gen
    import i2c_cond_pkg::*;
#(
    parameter int STD_SETUP   = 20,
    parameter int STD_HOLD    = 20,
    parameter int STD_BB      = 12,
    parameter int FAST_SETUP  = 10,
    parameter int FAST_HOLD   = 10,
    parameter int FAST_BB     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       fast_mode,
    input  logic       wr_stat,
    input  logic [2:0] wr_mode,
    input  logic       bit_tick,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    output logic       bus_busy,
    output logic [2:0] bit_cnt,
    output logic       byte_go
);

    localparam int MAX_A = (STD_SETUP > STD_HOLD) ? STD_SETUP : STD_HOLD;
    localparam int MAX_B = (MAX_A > STD_BB) ? MAX_A : STD_BB;
    localparam int MAX_C = (FAST_SETUP > FAST_HOLD) ? FAST_SETUP : FAST_HOLD;
    localparam int MAX_D = (MAX_C > FAST_BB) ? MAX_C : FAST_BB;
    localparam int MAXN  = (MAX_B > MAX_D) ? MAX_B : MAX_D;
    localparam int CW    = $clog2(MAXN + 1);
    localparam logic [2:0] LAST_BIT = 3'd7;

    cg_state_t    state_q, state_d;
    logic [CW-1:0] setup_n, hold_n, bb_n;
    logic [CW-1:0] tm_val;
    logic          tm_load, tm_done;
    logic          own_set, own_clr;
    logic          seen_start, seen_stop;
    logic          do_start, do_stop, do_arm;
    logic [2:0]    cnt_q;

    // mode-dependent counts
    always_comb begin
        if (fast_mode) begin
            setup_n = CW'(FAST_SETUP);
            hold_n  = CW'(FAST_HOLD);
            bb_n    = CW'(FAST_BB);
        end else begin
            setup_n = CW'(STD_SETUP);
            hold_n  = CW'(STD_HOLD);
            bb_n    = CW'(STD_BB);
        end
    end

    always_comb begin
        do_start = enable && wr_stat && (wr_mode == OP_START);
        do_stop  = enable && wr_stat && (wr_mode == OP_STOP);
        do_arm   = enable && wr_stat && (wr_mode == OP_ARM);
    end

    i2c_cond_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .seen_start (seen_start),
        .seen_stop  (seen_stop)
    );

    i2c_cond_phase_timer #(.W(CW)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tm_load),
        .load_val (tm_val),
        .done     (tm_done)
    );

    i2c_cond_busy #(.W(CW)) u_busy (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .idle       (state_q == S_IDLE),
        .own_set    (own_set),
        .own_clr    (own_clr),
        .delay      (bb_n),
        .seen_start (seen_start),
        .seen_stop  (seen_stop),
        .busy       (bus_busy)
    );

    // next state and phase loads
    always_comb begin
        state_d = state_q;
        tm_load = 1'b0;
        tm_val  = '0;
        own_set = 1'b0;
        own_clr = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (do_start && !bus_busy) begin
                    state_d = S_SETUP;
                    tm_load = 1'b1;
                    tm_val  = setup_n - CW'(1);
                end
            end
            S_SETUP: begin
                if (tm_done) begin
                    state_d = S_HOLD;
                    tm_load = 1'b1;
                    tm_val  = hold_n - CW'(1);
                    own_set = 1'b1;
                end
            end
            S_HOLD: begin
                if (tm_done) state_d = S_BYTE;
            end
            S_BYTE: begin
                if (bit_tick && cnt_q == LAST_BIT) state_d = S_HELD;
            end
            S_HELD: begin
                if (do_stop)     state_d = S_DROP;
                else if (do_arm) state_d = S_ARM;
            end
            S_ARM: begin
                if (do_start) begin
                    state_d = S_SETUP;
                    tm_load = 1'b1;
                    tm_val  = setup_n - CW'(1);
                end else if (do_stop) begin
                    state_d = S_DROP;
                end
            end
            S_DROP: begin
                state_d = S_PSETUP;
                tm_load = 1'b1;
                tm_val  = setup_n - CW'(1);
            end
            S_PSETUP: begin
                if (tm_done) begin
                    state_d = S_IDLE;
                    own_clr = 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
        if (!enable) begin
            state_d = S_IDLE;
            tm_load = 1'b0;
            own_set = 1'b0;
            own_clr = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (state_q == S_HOLD && state_d == S_BYTE)
            cnt_q <= '0;
        else if (state_q == S_BYTE && state_d == S_BYTE && bit_tick)
            cnt_q <= cnt_q + 3'd1;
    end

    // line outputs
    always_comb begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        unique case (state_q)
            S_IDLE, S_SETUP: begin
                scl_drive_low = 1'b0;
                sda_drive_low = 1'b0;
            end
            S_HOLD: sda_drive_low = 1'b1;
            S_BYTE, S_HELD, S_ARM: scl_drive_low = 1'b1;
            S_DROP: begin
                scl_drive_low = 1'b1;
                sda_drive_low = 1'b1;
            end
            S_PSETUP: sda_drive_low = 1'b1;
            default: begin
                scl_drive_low = 1'b0;
                sda_drive_low = 1'b0;
            end
        endcase
    end

    assign byte_go = (state_q == S_BYTE);
    assign bit_cnt = cnt_q;

endmodule

// File: rtl/i2c_cond_gen_chk.sv
module i2c_cond_gen_chk
    import i2c_cond_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       wr_stat,
    input logic [2:0] wr_mode,
    input logic       bit_tick,
    input logic       scl_drive_low,
    input logic       sda_drive_low,
    input logic       bus_busy,
    input logic [2:0] bit_cnt,
    input logic       byte_go,
    input cg_state_t  state
);

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bus_busy && !scl_drive_low && !sda_drive_low));

    // R3
    go_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(byte_go) |-> (bit_cnt == 3'd0 && scl_drive_low && !sda_drive_low));

    // R11
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && byte_go && bit_tick && bit_cnt != 3'd7) |=> (bit_cnt == $past(bit_cnt) + 3'd1));

    // R8
    dup_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state == S_IDLE && bus_busy && wr_stat && wr_mode == OP_START) |=> (state == S_IDLE));

    // R6
    stop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PSETUP) |-> bus_busy);

endmodule

bind i2c_cond_gen i2c_cond_gen_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .wr_stat       (wr_stat),
    .wr_mode       (wr_mode),
    .bit_tick      (bit_tick),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .bus_busy      (bus_busy),
    .bit_cnt       (bit_cnt),
    .byte_go       (byte_go),
    .state         (state_q)
);

// File: tb/i2c_cond_gen_test.sv
module i2c_cond_gen_test;

    logic       clk = 1'b0;
    logic       rst_n, enable, fast_mode, wr_stat, bit_tick;
    logic [2:0] wr_mode;
    logic       ext_scl_low, ext_sda_low;
    logic       scl_line, sda_line;
    logic       scl_drive_low, sda_drive_low, bus_busy, byte_go;
    logic [2:0] bit_cnt;
    int         total = 0;
    int         bad = 0;

    always #10 clk = ~clk;

    assign scl_line = !(scl_drive_low || ext_scl_low);
    assign sda_line = !(sda_drive_low || ext_sda_low);

    i2c_cond_gen uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_mode(fast_mode),
        .wr_stat(wr_stat), .wr_mode(wr_mode), .bit_tick(bit_tick),
        .scl_in(scl_line), .sda_in(sda_line),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .bus_busy(bus_busy), .bit_cnt(bit_cnt), .byte_go(byte_go)
    );

    function automatic int s_of(bit f); return f ? 10 : 20; endfunction
    function automatic int h_of(bit f); return f ? 10 : 20; endfunction
    function automatic int b_of(bit f); return f ? 6 : 12; endfunction

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] d);
        @(negedge clk);
        wr_stat = 1'b1;
        wr_mode = d[7:5];
        @(posedge clk);
        #1;
        wr_stat = 1'b0;
    endtask

    task automatic go(inout int pos, input int k);
        if (k > pos) begin
            repeat (k - pos) @(posedge clk);
            #1;
            pos = k;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic tick();
        @(negedge clk);
        bit_tick = 1'b1;
        @(posedge clk);
        #1;
        bit_tick = 1'b0;
    endtask

    // START (or repeated START when rs=1) from the write edge
    task automatic start_seq(bit f, bit rs);
        int p = 0;
        int s = s_of(f);
        int h = h_of(f);
        int b = b_of(f);
        string rq = f ? "R5" : "R2";
        wr(8'hF0);
        go(p, s - 1);
        chk(rq, "sda before setup end", sda_drive_low, 0);
        chk("R2", "scl in setup", scl_drive_low, 0);
        go(p, s);
        chk(rq, "sda at setup end", sda_drive_low, 1);
        go(p, s + b - 1);
        chk(rs ? "R7" : "R4", "busy before set", bus_busy, rs ? 1 : 0);
        go(p, s + b);
        chk(rs ? "R7" : "R4", "busy at set", bus_busy, 1);
        go(p, s + h - 1);
        chk("R3", "scl before hold end", scl_drive_low, 0);
        go(p, s + h);
        chk("R3", "scl at hold end", scl_drive_low, 1);
        chk("R3", "bit_cnt zero", bit_cnt, 0);
        chk("R3", "byte_go", byte_go, 1);
    endtask

    // stub byte: eight ticks with random gaps; writes in BYTE are ignored
    task automatic byte_seq();
        for (int i = 0; i < 8; i++) begin
            idle($urandom_range(0, 3));
            if (i == 2) begin
                wr(8'hD0);
                chk("R12", "stop ignored in byte", scl_drive_low, 1);
            end
            tick();
            if (i == 2) chk("R11", "count after 3 ticks", bit_cnt, 3);
        end
        chk("R11", "byte_go after byte", byte_go, 0);
        chk("R11", "scl held", scl_drive_low, 1);
        chk("R11", "final count", bit_cnt, 7);
    endtask

    task automatic stop_seq(bit f);
        int p = 0;
        int s = s_of(f);
        int b = b_of(f);
        wr(8'hD0);
        chk("R6", "drop scl", scl_drive_low, 1);
        chk("R6", "drop sda", sda_drive_low, 1);
        go(p, 1);
        chk("R6", "scl released", scl_drive_low, 0);
        go(p, s);
        chk("R6", "sda still low", sda_drive_low, 1);
        go(p, s + 1);
        chk("R6", "sda released", sda_drive_low, 0);
        go(p, s + b);
        chk("R6", "busy held", bus_busy, 1);
        go(p, s + b + 1);
        chk("R6", "busy cleared", bus_busy, 0);
    endtask

    task automatic restart_arm();
        wr(8'h20);
        chk("R7", "arm scl low", scl_drive_low, 1);
        chk("R7", "arm sda released", sda_drive_low, 0);
        idle($urandom_range(1, 6));
        chk("R7", "arm busy", bus_busy, 1);
    endtask

    task automatic foreign_block(bit f);
        int hits = 0;
        fast_mode = f;
        @(negedge clk);
        ext_sda_low = 1'b1;
        idle(5);
        chk("R9", "foreign start sets busy", bus_busy, 1);
        wr(8'hF0);
        for (int i = 0; i < s_of(f) + h_of(f) + 2; i++) begin
            if (scl_drive_low || sda_drive_low || byte_go) hits++;
            idle(1);
        end
        chk("R8", "no lines after blocked start", hits, 0);
        chk("R8", "bit_cnt unchanged", bit_cnt, 7);
        @(negedge clk);
        ext_sda_low = 1'b0;
        idle(5);
        chk("R9", "foreign stop clears busy", bus_busy, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd9173));
        rst_n = 1'b0; enable = 1'b1; fast_mode = 1'b0; wr_stat = 1'b0;
        wr_mode = 3'b000; bit_tick = 1'b0; ext_scl_low = 1'b0; ext_sda_low = 1'b0;
        idle(3);
        chk("R1", "reset scl", scl_drive_low, 0);
        chk("R1", "reset sda", sda_drive_low, 0);
        chk("R1", "reset busy", bus_busy, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        chk("R1", "post reset count", bit_cnt, 0);
        chk("R1", "post reset go", byte_go, 0);

        // R12: stop and arm writes while idle
        wr(8'hD0);
        wr(8'h20);
        idle(30);
        chk("R12", "idle writes scl", scl_drive_low, 0);
        chk("R12", "idle writes sda", sda_drive_low, 0);
        chk("R12", "idle writes busy", bus_busy, 0);

        // standard mode: start, byte, stop
        start_seq(1'b0, 1'b0);
        byte_seq();
        stop_seq(1'b0);

        // high-speed: start, byte, restart, byte, stop
        fast_mode = 1'b1;
        start_seq(1'b1, 1'b0);
        byte_seq();
        restart_arm();
        start_seq(1'b1, 1'b1);
        byte_seq();
        stop_seq(1'b1);

        // duplicate guard
        foreign_block(1'b0);

        // R10: disabled interface ignores everything
        @(negedge clk);
        enable = 1'b0;
        ext_sda_low = 1'b1;
        idle(5);
        wr(8'hF0);
        idle(45);
        chk("R10", "disabled busy", bus_busy, 0);
        chk("R10", "disabled sda", sda_drive_low, 0);
        @(negedge clk);
        ext_sda_low = 1'b0;
        idle(5);
        @(negedge clk);
        enable = 1'b1;
        idle(2);

        // R10: disable in the middle of a START hold, timer pending
        fast_mode = 1'b0;
        wr(8'hF0);
        idle(22);
        @(negedge clk);
        enable = 1'b0;
        @(posedge clk);
        #1;
        chk("R10", "mid-start sda", sda_drive_low, 0);
        chk("R10", "mid-start busy", bus_busy, 0);
        idle(20);
        chk("R10", "mid-start busy later", bus_busy, 0);
        @(negedge clk);
        enable = 1'b1;
        idle(3);

        // random scenarios
        for (int it = 0; it < 14; it++) begin
            bit f = 1'($urandom_range(0, 1));
            int sc = $urandom_range(0, 2);
            fast_mode = f;
            idle($urandom_range(2, 9));
            if (sc == 2) begin
                foreign_block(f);
            end else begin
                start_seq(f, 1'b0);
                byte_seq();
                if (sc == 1) begin
                    restart_arm();
                    start_seq(f, 1'b1);
                    byte_seq();
                end
                stop_seq(f);
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule